// File: doc/BRIEF.md
# Bus trace recorder with timestamps

This block records processor bus activity into a circular trace memory. It takes one sample on every bus clock in which capture is running and the store qualifier is high. A bus cycle that lasts several clocks therefore leaves several consecutive frames that carry the same address. Each frame holds the following fields:

- the address and the 32-bit data;
- four active-low byte-lane enables;
- a three-bit cycle-kind code;
- the two active-low ready strobes;
- four bus status lines;
- the value of a free-running timestamp counter at the moment of capture.

The counter advances in every clock whether or not a frame is stored, so gaps made by the qualifier show up as real elapsed time.

Capture starts on the rising edge of `run`, and this clears the previous trace. When `run` falls, the most recently stored frame becomes frame 0. Readout uses a signed index that is zero or negative: index 0 is the newest frame, and -1, -2 and so on reach back in time. The read port returns the stored fields one clock after the index is presented. It also returns the frame's timestamp as a signed offset from frame 0. A request that points at a location never written in the current trace returns `rd_valid` low. So does any request made while capture is running.

Top module: `trc_recorder`

## Requirements
- R1: After reset the stored-frame count is zero, so `rd_valid` is low for every index, including 0.
- R2: The timestamp advances by one tick per clock (default prescale 1) in every clock, whether or not a frame is stored.
- R3: A frame is stored in each clock where `run` and `qual` are both high; a clock with `qual` low stores nothing.
- R4: After a stop, index 0 returns the last stored frame and index -k returns the frame stored k captures earlier.
- R5: `rd_ts` equals the stored timestamp of the addressed frame minus that of frame 0, as a signed value (zero or negative).
- R6: Fields are returned exactly as sampled: `rd_be_n` keeps bit n for byte lane n; `rd_kind` is {`bus_mio`, `bus_dc`, `bus_wr`} in bits 2..0; `rd_rdy_n` is {`bus_rdy_n`, `bus_brdy_n`}; `rd_stat` is {`bus_sz8_n`, `bus_sz16_n`, `bus_smm`, `bus_cache_n`} in bits 3..0.
- R7: The write pointer wraps at DEPTH and the frame count saturates at DEPTH: after more than DEPTH captures, index -(DEPTH-1) is valid and index -DEPTH is not.
- R8: An index that is positive, or whose magnitude is not below the stored-frame count, returns `rd_valid` low.
- R9: While `run` is high, `rd_valid` is low.
- R10: A rising edge of `run` discards the previous trace; only frames stored after it can be read.
- R11: Read results and `rd_valid` appear on the clock edge after the one that samples `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Capture enable; rise starts a new trace, fall freezes it |
| qual | input | 1 | Store qualifier for the current clock |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | 32 | Bus data |
| bus_be_n | input | 4 | Byte-lane enables, active low |
| bus_mio | input | 1 | 1 = memory, 0 = I/O |
| bus_dc | input | 1 | 1 = data, 0 = code |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_rdy_n | input | 1 | Ready, active low |
| bus_brdy_n | input | 1 | Burst ready, active low |
| bus_sz8_n | input | 1 | 8-bit bus size request, active low |
| bus_sz16_n | input | 1 | 16-bit bus size request, active low |
| bus_smm | input | 1 | System management active |
| bus_cache_n | input | 1 | Cache enable, active low |
| rd_idx | input | IW | Signed frame index, 0 = newest |
| rd_valid | output | 1 | Read result refers to a stored frame |
| rd_addr | output | ADDR_W | Stored address |
| rd_data | output | 32 | Stored data |
| rd_be_n | output | 4 | Stored byte enables |
| rd_kind | output | 3 | Stored cycle-kind code |
| rd_rdy_n | output | 2 | Stored ready strobes |
| rd_stat | output | 4 | Stored status lines |
| rd_ts | output | TS_W | Signed timestamp offset from frame 0 |

## Verification
The hardest state to reach is the wrapped trace. There, the frame count has saturated and the write pointer has overwritten the oldest locations, so the frame at -(DEPTH-1) and the refusal at -DEPTH both depend on the wrap arithmetic. The bench drives more than DEPTH qualified frames in a single run, each with fields derived from a sequence number. It then reads the two boundary indices and compares them against its own record of what was captured. Qualifier gaps are produced by patterns with `qual` low for several clocks, which makes the timestamp offsets differ from the index distances.

// File: rtl/trc_pkg.sv
package trc_pkg;

   // Per-frame bus fields other than the address and the timestamp.
   typedef struct packed {
      logic [31:0] data;
      logic [3:0]  be_n;   // bit n = byte lane n, 0 = lane valid
      logic [2:0]  kind;   // {memory_not_io, data_not_code, write_not_read}
      logic [1:0]  rdy_n;  // {ready_n, burst_ready_n}
      logic [3:0]  stat;   // {size8_n, size16_n, smm_active, cache_en_n}
   } lanes_t;

   localparam int LANES_W = $bits(lanes_t);

endpackage

// File: rtl/trc_stamp.sv
module trc_stamp #(
   parameter int TS_W = 32,
   parameter int DIV  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] stamp
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("trc_stamp: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) stamp <= '0;
            else        stamp <= stamp + 1'b1;
         end
      end else begin : g_prescaled
         localparam int PSW = $clog2(DIV);
         logic [PSW-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pre   <= '0;
               stamp <= '0;
            end else if (pre == PSW'(DIV-1)) begin
               pre   <= '0;
               stamp <= stamp + 1'b1;
            end else begin
               pre   <= pre + 1'b1;
            end
         end
      end
   endgenerate

   // R2
   stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((stamp - $past(stamp)) <= TS_W'(1)));

endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [PW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/trc_wrctl.sv
module trc_wrctl #(
   parameter int DEPTH = 2048,
   parameter int TS_W  = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            qual,
   input  logic [TS_W-1:0] stamp,
   output logic            we,
   output logic [PW-1:0]   waddr,
   output logic [CW-1:0]   cnt,
   output logic [PW-1:0]   head,
   output logic [TS_W-1:0] head_ts
);

   logic          run_q;
   logic          start;
   logic [PW-1:0] wptr;
   logic [PW-1:0] wptr_base;
   logic [CW-1:0] cnt_base;

   assign start     = run & ~run_q;
   assign wptr_base = start ? '0 : wptr;
   assign cnt_base  = start ? '0 : cnt;
   assign we        = run & qual;
   assign waddr     = wptr_base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         wptr    <= '0;
         cnt     <= '0;
         head    <= '0;
         head_ts <= '0;
      end else begin
         run_q <= run;
         if (we) begin
            wptr    <= wptr_base + 1'b1;
            head    <= wptr_base;
            head_ts <= stamp;
            cnt     <= (cnt_base == CW'(DEPTH)) ? cnt_base : cnt_base + 1'b1;
         end else if (start) begin
            wptr <= '0;
            cnt  <= '0;
         end
      end
   end

   // R7
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(we) && !$past(start)) |-> $stable(cnt));

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(start)) |-> (cnt <= CW'(1)));

endmodule

// File: rtl/trc_rdport.sv
module trc_rdport #(
   parameter int DEPTH = 2048,
   parameter int TS_W  = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int IW   = PW + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic signed [IW-1:0]   rd_idx,
   input  logic [IW-1:0]          cnt,
   input  logic [PW-1:0]          head,
   input  logic [TS_W-1:0]        head_ts,
   input  logic [TS_W-1:0]        q_ts,
   output logic [PW-1:0]          raddr,
   output logic                   rd_valid,
   output logic signed [TS_W-1:0] rd_ts
);

   logic          nonpos;
   logic [IW-1:0] mag;
   logic          ok;
   logic [TS_W-1:0] base_q;

   assign nonpos = rd_idx[IW-1] | (rd_idx == '0);
   assign mag    = IW'(-rd_idx);
   assign ok     = !run && nonpos && (mag < cnt);
   assign raddr  = head + rd_idx[PW-1:0];
   assign rd_ts  = signed'(q_ts - base_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         base_q   <= '0;
      end else begin
         rd_valid <= ok;
         base_q   <= head_ts;
      end
   end

   // R9
   rd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(run)) |-> !rd_valid);

   // R8
   rd_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(rd_idx[IW-1]) && ($past(rd_idx) != '0)) |-> !rd_valid);

   // R1
   rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(cnt) == '0)) |-> !rd_valid);

endmodule

// File: rtl/trc_recorder.sv
module trc_recorder #(
   parameter int ADDR_W    = 32,
   parameter int DEPTH     = 2048,
   parameter int TS_W      = 32,
   parameter int STAMP_DIV = 1,
   localparam int PW       = $clog2(DEPTH),
   localparam int IW       = PW + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   qual,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_data,
   input  logic [3:0]             bus_be_n,
   input  logic                   bus_mio,
   input  logic                   bus_dc,
   input  logic                   bus_wr,
   input  logic                   bus_rdy_n,
   input  logic                   bus_brdy_n,
   input  logic                   bus_sz8_n,
   input  logic                   bus_sz16_n,
   input  logic                   bus_smm,
   input  logic                   bus_cache_n,
   input  logic signed [IW-1:0]   rd_idx,
   output logic                   rd_valid,
   output logic [ADDR_W-1:0]      rd_addr,
   output logic [31:0]            rd_data,
   output logic [3:0]             rd_be_n,
   output logic [2:0]             rd_kind,
   output logic [1:0]             rd_rdy_n,
   output logic [3:0]             rd_stat,
   output logic signed [TS_W-1:0] rd_ts
);
   import trc_pkg::*;

   localparam int WORD_W = TS_W + ADDR_W + LANES_W;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("trc_recorder: DEPTH must be a power of two of at least 2");
      end
      if (TS_W < 32) begin : g_bad_ts
         $error("trc_recorder: TS_W must be at least 32");
      end
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("trc_recorder: ADDR_W must lie in 1..64");
      end
   endgenerate

   logic [TS_W-1:0]   stamp;
   logic              we;
   logic [PW-1:0]     waddr;
   logic [IW-1:0]     cnt;
   logic [PW-1:0]     head;
   logic [TS_W-1:0]   head_ts;
   logic [PW-1:0]     raddr;
   lanes_t            in_lanes;
   lanes_t            out_lanes;
   logic [WORD_W-1:0] wword;
   logic [WORD_W-1:0] rword;
   logic [TS_W-1:0]   q_ts;

   always_comb begin
      in_lanes.data  = bus_data;
      in_lanes.be_n  = bus_be_n;
      in_lanes.kind  = {bus_mio, bus_dc, bus_wr};
      in_lanes.rdy_n = {bus_rdy_n, bus_brdy_n};
      in_lanes.stat  = {bus_sz8_n, bus_sz16_n, bus_smm, bus_cache_n};
   end

   assign wword = {stamp, bus_addr, in_lanes};

   trc_stamp #(.TS_W(TS_W), .DIV(STAMP_DIV)) u_stamp (
      .clk(clk), .rst_n(rst_n), .stamp(stamp));

   trc_wrctl #(.DEPTH(DEPTH), .TS_W(TS_W)) u_wrctl (
      .clk(clk), .rst_n(rst_n), .run(run), .qual(qual), .stamp(stamp),
      .we(we), .waddr(waddr), .cnt(cnt), .head(head), .head_ts(head_ts));

   trc_ram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wword),
      .raddr(raddr), .rdata(rword));

   trc_rdport #(.DEPTH(DEPTH), .TS_W(TS_W)) u_rdport (
      .clk(clk), .rst_n(rst_n), .run(run), .rd_idx(rd_idx), .cnt(cnt),
      .head(head), .head_ts(head_ts), .q_ts(q_ts), .raddr(raddr),
      .rd_valid(rd_valid), .rd_ts(rd_ts));

   assign q_ts      = rword[WORD_W-1 -: TS_W];
   assign rd_addr   = rword[LANES_W +: ADDR_W];
   assign out_lanes = lanes_t'(rword[LANES_W-1:0]);
   assign rd_data   = out_lanes.data;
   assign rd_be_n   = out_lanes.be_n;
   assign rd_kind   = out_lanes.kind;
   assign rd_rdy_n  = out_lanes.rdy_n;
   assign rd_stat   = out_lanes.stat;

   // R5
   ts_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ts != '0) |-> rd_ts[TS_W-1]);

endmodule

// File: tb/tb_trc_recorder.sv
module tb_trc_recorder;

   localparam int DEPTH = 2048;
   localparam int IW    = $clog2(DEPTH) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0;
   logic qual = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_data = '0;
   logic [3:0]  bus_be_n = '1;
   logic bus_mio = 0, bus_dc = 0, bus_wr = 0, bus_rdy_n = 1, bus_brdy_n = 1;
   logic bus_sz8_n = 1, bus_sz16_n = 1, bus_smm = 0, bus_cache_n = 1;
   logic signed [IW-1:0] rd_idx = '0;
   logic        rd_valid;
   logic [31:0] rd_addr, rd_data;
   logic [3:0]  rd_be_n, rd_stat;
   logic [2:0]  rd_kind;
   logic [1:0]  rd_rdy_n;
   logic signed [31:0] rd_ts;

   int n_chk = 0;
   int n_bad = 0;
   int t = 0;
   int seq = 0;
   int n_rec = 0;
   int m_seq [0:4095];
   int m_ts  [0:4095];
   bit done = 0;

   always #2.5 clk = ~clk;

   trc_recorder #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .qual(qual),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_be_n(bus_be_n),
      .bus_mio(bus_mio), .bus_dc(bus_dc), .bus_wr(bus_wr),
      .bus_rdy_n(bus_rdy_n), .bus_brdy_n(bus_brdy_n),
      .bus_sz8_n(bus_sz8_n), .bus_sz16_n(bus_sz16_n), .bus_smm(bus_smm),
      .bus_cache_n(bus_cache_n), .rd_idx(rd_idx), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_be_n(rd_be_n),
      .rd_kind(rd_kind), .rd_rdy_n(rd_rdy_n), .rd_stat(rd_stat), .rd_ts(rd_ts));

   function automatic logic [76:0] fields(input int s);
      logic [31:0] a, d;
      a = 32'h0000_2000 + 32'((s / 2) * 4);
      d = (32'(s) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      return {a, d, 4'(s), 3'(s >> 4), 2'(s >> 7), 4'(s >> 9)};
   endfunction

   task automatic check(input string req, input bit ok, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      t++;
      @(negedge clk);
   endtask

   task automatic drive(input bit q);
      logic [76:0] f;
      f = fields(seq);
      bus_addr = f[76:45]; bus_data = f[44:13]; bus_be_n = f[12:9];
      {bus_mio, bus_dc, bus_wr} = f[8:6];
      {bus_rdy_n, bus_brdy_n} = f[5:4];
      {bus_sz8_n, bus_sz16_n, bus_smm, bus_cache_n} = f[3:0];
      run = 1'b1;
      qual = q;
      if (q) begin
         m_seq[n_rec] = seq;
         m_ts[n_rec] = t;
         n_rec++;
      end
      seq++;
      step();
   endtask

   task automatic start_run();
      n_rec = 0;
   endtask

   task automatic stop_run();
      run = 1'b0;
      qual = 1'b0;
      step();
   endtask

   // R11: result sampled one edge after rd_idx is applied
   task automatic read_chk(input int idx, input bit exp_v, input string req);
      int rec;
      logic [76:0] f;
      logic [76:0] got;
      logic signed [31:0] ets;
      rd_idx = idx[IW-1:0];
      step();
      check({req, " valid"}, rd_valid === exp_v, 128'(rd_valid), 128'(exp_v));
      if (exp_v && rd_valid === 1'b1) begin
         rec = n_rec - 1 + idx;
         f = fields(m_seq[rec]);
         got = {rd_addr, rd_data, rd_be_n, rd_kind, rd_rdy_n, rd_stat};
         check({req, " fields R6"}, got === f, 128'(got), 128'(f));
         ets = 32'(m_ts[rec] - m_ts[n_rec-1]);
         check({req, " ts R5"}, rd_ts === ets, 128'(rd_ts), 128'(ets));
      end
   endtask

   task automatic t_reset();
      read_chk(0, 1'b0, "R1 empty idx0");
      read_chk(-1, 1'b0, "R1 empty idx-1");
   endtask

   task automatic t_basic();
      start_run();
      for (int i = 0; i < 12; i++) drive(1'b1);
      stop_run();
      read_chk(0, 1'b1, "R4 newest");
      read_chk(-1, 1'b1, "R4 idx-1");
      read_chk(-5, 1'b1, "R4 idx-5");
      read_chk(-11, 1'b1, "R4 oldest");
      read_chk(-12, 1'b0, "R8 beyond count");
      read_chk(1, 1'b0, "R8 positive");
      read_chk(-2048, 1'b0, "R8 min index");
   endtask

   task automatic t_qual();
      bit pat [9] = '{1, 0, 0, 1, 1, 0, 0, 0, 1};
      start_run();
      foreach (pat[i]) drive(pat[i]);
      stop_run();
      // R3 four frames stored; R2 timestamp gaps span the skipped clocks
      read_chk(0, 1'b1, "R3 R2 gap newest");
      read_chk(-1, 1'b1, "R3 R2 gap -1");
      read_chk(-2, 1'b1, "R3 R2 gap -2");
      read_chk(-3, 1'b1, "R3 R2 gap -3");
      read_chk(-4, 1'b0, "R3 no extra frame");
   endtask

   task automatic t_runblock();
      start_run();
      for (int i = 0; i < 3; i++) drive(1'b1);
      qual = 1'b0;
      read_chk(0, 1'b0, "R9 running");
      stop_run();
      read_chk(0, 1'b1, "R9 after stop");
   endtask

   task automatic t_restart();
      start_run();
      for (int i = 0; i < 2; i++) drive(1'b1);
      stop_run();
      read_chk(-1, 1'b1, "R10 new frame");
      read_chk(-2, 1'b0, "R10 old trace gone");
   endtask

   task automatic t_wrap();
      start_run();
      for (int i = 0; i < DEPTH + 52; i++) drive(1'b1);
      stop_run();
      read_chk(0, 1'b1, "R7 newest after wrap");
      read_chk(-1, 1'b1, "R7 idx-1 after wrap");
      read_chk(-(DEPTH - 1), 1'b1, "R7 oldest kept");
      read_chk(-DEPTH, 1'b0, "R7 saturated count");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_qual();
      t_runblock();
      t_restart();
      t_wrap();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule